// File: doc/BRIEF.md
# Port Access Decoder with Cross-Clock Mailboxes

This block sits behind one bidirectional 36-bit data port of a dual-clock buffer. On every port-A clock it turns four control inputs into one action: push a word into the FIFO, load the outgoing mailbox, fetch the incoming mailbox, or do nothing. Separately from the clocked action, it decodes when the port's data pins should be driven and what they should carry. The FIFO storage and the pad drivers are outside the block; it only produces their write strobe and output enable.

Two single-word mailboxes let a word cross between the port-A and port-B clock domains without going through the FIFO. The outbound mailbox is loaded from port A and consumed on the port-B side. The inbound mailbox is loaded on the port-B side and fetched through port A. Each mailbox has an active-low "occupied" flag on its writer's side and a "word waiting" flag on its reader's side. Both are kept coherent by toggle signals that pass through two-stage synchronizers in each direction.

Top module: `pad_access_mbox`

## Requirements
- R1: `a_drive` is 1 exactly when `a_cs_n` is 0 and `a_wr` is 0, whatever the state of `a_en` and `a_mbx`.
- R2: `a_fifo_we` is 1 exactly when `a_cs_n`=0, `a_wr`=1, `a_en`=1, `a_mbx`=0 and `a_fifo_ready`=1.
- R3: A port-A clock edge with `a_cs_n`=0, `a_wr`=1, `a_en`=1, `a_mbx`=1 while `a_mbf1`=1 stores `a_din` in the outbound mailbox, and `a_mbf1` reads 0 after that edge.
- R4: The outbound mailbox ignores a store while `a_mbf1` is 0. `b_mail1_data` keeps the earlier word.
- R5: After a store into the outbound mailbox, `b_mail1_full` is 0 after the second port-B edge and 1 after the third, and `b_mail1_data` then equals the stored word.
- R6: A port-B edge with `b_mb1_rd`=1 and `b_mail1_full`=1 clears `b_mail1_full` after that edge. `a_mbf1` returns to 1 after the third port-A edge that follows, and not before.
- R7: A port-B edge with `b_mb2_wr`=1 while `b_mbf2`=1 stores `b_din` in the inbound mailbox and `b_mbf2` reads 0 after it. `a_mail2_full` rises after the third port-A edge that follows, and `a_dout` then equals the word. A store while `b_mbf2` is 0 is ignored.
- R8: `a_dout` always presents the inbound mailbox word. A port-A edge with `a_cs_n`=0, `a_wr`=0, `a_en`=1, `a_mbx`=1 while `a_mail2_full`=1 clears `a_mail2_full` after that edge. `b_mbf2` returns to 1 after the third port-B edge that follows, and not before.
- R9: With `a_cs_n`=1 or `a_en`=0, no action takes place: no FIFO strobe, no mailbox store, and no mailbox fetch.
- R10: Reset (`rst_a` and `rst_b`, synchronous, active high) leaves `a_mbf1`=1, `b_mbf2`=1, `a_mail2_full`=0 and `b_mail1_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port-A clock |
| rst_a | input | 1 | Synchronous reset, port-A domain |
| a_cs_n | input | 1 | Port select, active low |
| a_wr | input | 1 | 1 = port writes in, 0 = port reads out |
| a_en | input | 1 | Clocked access enable |
| a_mbx | input | 1 | 1 = access targets a mailbox instead of the FIFO |
| a_din | input | 36 | Word arriving on the port |
| a_fifo_ready | input | 1 | FIFO has room for a word |
| a_fifo_we | output | 1 | FIFO write strobe |
| a_drive | output | 1 | Output enable for the port data pins |
| a_dout | output | 36 | Word to drive: inbound mailbox contents |
| a_mbf1 | output | 1 | Outbound mailbox free (0 = occupied) |
| a_mail2_full | output | 1 | Inbound mailbox holds an unread word |
| clk_b | input | 1 | Port-B clock |
| rst_b | input | 1 | Synchronous reset, port-B domain |
| b_mb2_wr | input | 1 | Store `b_din` into the inbound mailbox |
| b_din | input | 36 | Word for the inbound mailbox |
| b_mb1_rd | input | 1 | Consume the outbound mailbox word |
| b_mbf2 | output | 1 | Inbound mailbox free (0 = occupied) |
| b_mail1_full | output | 1 | Outbound mailbox holds an unread word |
| b_mail1_data | output | 36 | Outbound mailbox contents |

## Verification
The drive enable and FIFO strobe are combinational, so they are sampled one nanosecond after the inputs change, before the next edge. A writer's own flag changes after the edge that performed the store or fetch, and it is checked just after that edge. A flag in the other domain changes only after that domain's third rising edge. The bench offsets the two clocks by a fixed phase so that edge count is exact, and it samples both after the second edge (expecting no change) and after the third (expecting the change).

// File: rtl/pad_pkg.sv
package pad_pkg;

    localparam int PAD_DATA_W   = 36;
    localparam int PAD_SYNC_STG = 2;

    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_FIFO_WR = 2'd1,
        ACT_MB1_WR  = 2'd2,
        ACT_MB2_RD  = 2'd3
    } pad_act_e;

    typedef struct packed {
        logic cs_n;
        logic wr;
        logic en;
        logic mbx;
    } pad_req_t;

    // Clocked action selected by one port request.
    function automatic pad_act_e pad_decode_act(input pad_req_t r);
        pad_act_e a;
        a = ACT_IDLE;
        if (!r.cs_n && r.en) begin
            if (r.wr)
                a = r.mbx ? ACT_MB1_WR : ACT_FIFO_WR;
            else if (r.mbx)
                a = ACT_MB2_RD;
        end
        return a;
    endfunction

    // Output drive depends only on select and direction.
    function automatic logic pad_decode_drive(input pad_req_t r);
        return !r.cs_n && !r.wr;
    endfunction

endpackage

// File: rtl/pad_decode.sv
module pad_decode
    import pad_pkg::*;
(
    input  pad_req_t req,
    input  logic     fifo_ready,
    output pad_act_e act,
    output logic     drive,
    output logic     fifo_we
);
    always_comb begin
        act     = pad_decode_act(req);
        drive   = pad_decode_drive(req);
        fifo_we = (act == ACT_FIFO_WR) && fifo_ready;
    end
endmodule

// File: rtl/pad_tog_sync.sv
module pad_tog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_in,
    output logic pulse
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], tog_in};
    end

    // One-cycle pulse each time the synchronized toggle changes.
    assign pulse = chain[LAST] ^ chain[LAST-1];
endmodule

// File: rtl/pad_mailbox.sv
module pad_mailbox #(
    parameter int DATA_W   = 36,
    parameter int SYNC_STG = 2
) (
    input  logic              clk_w,
    input  logic              rst_w,
    input  logic              wr,
    input  logic [DATA_W-1:0] din,
    output logic              free_w,
    input  logic              clk_r,
    input  logic              rst_r,
    input  logic              rd,
    output logic              full_r,
    output logic [DATA_W-1:0] dout
);
    logic              w_tog, r_tog;
    logic              req_pulse, ack_pulse;
    logic [DATA_W-1:0] word_q;

    // Writer side: holds the word, owns the free flag.
    always_ff @(posedge clk_w) begin
        if (rst_w) begin
            word_q <= '0;
            free_w <= 1'b1;
            w_tog  <= 1'b0;
        end else if (wr && free_w) begin
            word_q <= din;
            free_w <= 1'b0;
            w_tog  <= ~w_tog;
        end else if (ack_pulse) begin
            free_w <= 1'b1;
        end
    end

    // Reader side: owns the word-waiting flag.
    always_ff @(posedge clk_r) begin
        if (rst_r) begin
            full_r <= 1'b0;
            r_tog  <= 1'b0;
        end else if (rd && full_r) begin
            full_r <= 1'b0;
            r_tog  <= ~r_tog;
        end else if (req_pulse) begin
            full_r <= 1'b1;
        end
    end

    pad_tog_sync #(.STAGES(SYNC_STG)) u_req_sync (
        .clk    (clk_r),
        .rst    (rst_r),
        .tog_in (w_tog),
        .pulse  (req_pulse)
    );

    pad_tog_sync #(.STAGES(SYNC_STG)) u_ack_sync (
        .clk    (clk_w),
        .rst    (rst_w),
        .tog_in (r_tog),
        .pulse  (ack_pulse)
    );

    // Stable while full_r is set: the writer cannot reload until acknowledged.
    assign dout = word_q;
endmodule

// File: rtl/pad_access_mbox.sv
module pad_access_mbox
    import pad_pkg::*;
#(
    parameter int DATA_W   = PAD_DATA_W,
    parameter int SYNC_STG = PAD_SYNC_STG
) (
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              a_cs_n,
    input  logic              a_wr,
    input  logic              a_en,
    input  logic              a_mbx,
    input  logic [DATA_W-1:0] a_din,
    input  logic              a_fifo_ready,
    output logic              a_fifo_we,
    output logic              a_drive,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_mbf1,
    output logic              a_mail2_full,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              b_mb2_wr,
    input  logic [DATA_W-1:0] b_din,
    input  logic              b_mb1_rd,
    output logic              b_mbf2,
    output logic              b_mail1_full,
    output logic [DATA_W-1:0] b_mail1_data
);
    pad_req_t req;
    pad_act_e act;

    assign req = '{cs_n: a_cs_n, wr: a_wr, en: a_en, mbx: a_mbx};

    pad_decode u_dec (
        .req        (req),
        .fifo_ready (a_fifo_ready),
        .act        (act),
        .drive      (a_drive),
        .fifo_we    (a_fifo_we)
    );

    // Outbound: written from port A, consumed on the port-B side.
    pad_mailbox #(.DATA_W(DATA_W), .SYNC_STG(SYNC_STG)) u_mb1 (
        .clk_w  (clk_a),
        .rst_w  (rst_a),
        .wr     (act == ACT_MB1_WR),
        .din    (a_din),
        .free_w (a_mbf1),
        .clk_r  (clk_b),
        .rst_r  (rst_b),
        .rd     (b_mb1_rd),
        .full_r (b_mail1_full),
        .dout   (b_mail1_data)
    );

    // Inbound: written on the port-B side, fetched through port A.
    pad_mailbox #(.DATA_W(DATA_W), .SYNC_STG(SYNC_STG)) u_mb2 (
        .clk_w  (clk_b),
        .rst_w  (rst_b),
        .wr     (b_mb2_wr),
        .din    (b_din),
        .free_w (b_mbf2),
        .clk_r  (clk_a),
        .rst_r  (rst_a),
        .rd     (act == ACT_MB2_RD),
        .full_r (a_mail2_full),
        .dout   (a_dout)
    );
endmodule

// File: rtl/pad_access_chk.sv
module pad_access_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk_a,
    input logic              rst_a,
    input logic              a_cs_n,
    input logic              a_wr,
    input logic              a_en,
    input logic              a_mbx,
    input logic [DATA_W-1:0] a_din,
    input logic              a_fifo_ready,
    input logic              a_fifo_we,
    input logic              a_drive,
    input logic [DATA_W-1:0] a_dout,
    input logic              a_mbf1,
    input logic              a_mail2_full,
    input logic              clk_b,
    input logic              rst_b,
    input logic              b_mb2_wr,
    input logic [DATA_W-1:0] b_din,
    input logic              b_mb1_rd,
    input logic              b_mbf2,
    input logic              b_mail1_full,
    input logic [DATA_W-1:0] b_mail1_data
);
    a_r2_strobe_not_driving: assert property (@(posedge clk_a) disable iff (rst_a)
        a_fifo_we |-> !a_drive);

    a_r3_store_marks_busy: assert property (@(posedge clk_a) disable iff (rst_a)
        (!a_cs_n && a_wr && a_en && a_mbx && a_mbf1) |=> !a_mbf1);

    a_r4_busy_word_stable: assert property (@(posedge clk_a) disable iff (rst_a)
        !a_mbf1 |=> $stable(b_mail1_data));

    a_r6_consume_clears: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_mb1_rd && b_mail1_full) |=> !b_mail1_full);

    a_r7_inbound_busy: assert property (@(posedge clk_b) disable iff (rst_b)
        (b_mb2_wr && b_mbf2) |=> !b_mbf2);

    a_r8_fetch_clears: assert property (@(posedge clk_a) disable iff (rst_a)
        (!a_cs_n && !a_wr && a_en && a_mbx && a_mail2_full) |=> !a_mail2_full);

    a_r9_idle_no_strobe: assert property (@(posedge clk_a) disable iff (rst_a)
        (a_cs_n || !a_en) |-> !a_fifo_we);

    a_r10_reset_a: assert property (@(posedge clk_a)
        rst_a |=> (a_mbf1 && !a_mail2_full));

    a_r10_reset_b: assert property (@(posedge clk_b)
        rst_b |=> (b_mbf2 && !b_mail1_full));
endmodule

bind pad_access_mbox pad_access_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_pad_access_mbox.sv
module sim_pad_access_mbox;
    localparam int W = 36;

    logic         clk_a = 1'b0, clk_b = 1'b0;
    logic         rst_a, rst_b;
    logic         a_cs_n, a_wr, a_en, a_mbx, a_fifo_ready;
    logic [W-1:0] a_din;
    logic         a_fifo_we, a_drive, a_mbf1, a_mail2_full;
    logic [W-1:0] a_dout;
    logic         b_mb2_wr, b_mb1_rd;
    logic [W-1:0] b_din;
    logic         b_mbf2, b_mail1_full;
    logic [W-1:0] b_mail1_data;

    int n_chk  = 0;
    int n_fail = 0;

    // 100 MHz; port-B edges trail port-A edges by 3 ns.
    always #5 clk_a = ~clk_a;
    initial begin
        #3;
        forever #5 clk_b = ~clk_b;
    end

    pad_access_mbox u0 (.*);

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic a_idle();
        a_cs_n = 1'b1; a_wr = 1'b0; a_en = 1'b0; a_mbx = 1'b0;
    endtask

    // One port-A access; combinational outputs checked before the edge.
    task automatic a_op(input logic cs_n, input logic wr, input logic en,
                        input logic mbx, input logic rdy, input logic [W-1:0] din);
        @(negedge clk_a);
        a_cs_n = cs_n; a_wr = wr; a_en = en; a_mbx = mbx;
        a_fifo_ready = rdy; a_din = din;
        #1;
        chk("R1 drive", W'(a_drive), W'(!cs_n && !wr));
        chk("R2 fifo strobe", W'(a_fifo_we), W'(!cs_n && wr && en && !mbx && rdy));
        @(posedge clk_a);
        #1;
        a_idle();
    endtask

    task automatic b_store(input logic [W-1:0] din);
        @(negedge clk_b);
        b_mb2_wr = 1'b1; b_din = din;
        @(posedge clk_b);
        #1;
        b_mb2_wr = 1'b0;
    endtask

    task automatic b_consume();
        @(negedge clk_b);
        b_mb1_rd = 1'b1;
        @(posedge clk_b);
        #1;
        b_mb1_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_a = 1'b1; rst_b = 1'b1;
        repeat (5) @(posedge clk_a);
        #1;
        chk("R10 a_mbf1", W'(a_mbf1), W'(1));
        chk("R10 b_mbf2", W'(b_mbf2), W'(1));
        chk("R10 a_mail2_full", W'(a_mail2_full), W'(0));
        chk("R10 b_mail1_full", W'(b_mail1_full), W'(0));
        @(negedge clk_a);
        rst_a = 1'b0; rst_b = 1'b0;
        @(posedge clk_b);
        #1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        a_idle();
        a_fifo_ready = 1'b0; a_din = '0;
        b_mb2_wr = 1'b0; b_mb1_rd = 1'b0; b_din = '0;
        do_reset();

        // Full decode sweep: cs_n, wr, en, mbx, fifo_ready.
        for (int i = 0; i < 32; i++) begin
            logic [4:0]   v;
            logic         exp_store;
            logic [W-1:0] w;
            v = 5'(i);
            w = {4'hA, 32'(i * 32'h0101_0101)};
            exp_store = !v[0] && v[1] && v[2] && v[3];
            a_op(v[0], v[1], v[2], v[3], v[4], w);
            if (exp_store) begin
                chk("R3 flag busy", W'(a_mbf1), W'(0));
                repeat (3) @(posedge clk_b);
                #1;
                chk("R5 word waiting", W'(b_mail1_full), W'(1));
                chk("R5 word value", b_mail1_data, w);
                b_consume();
                chk("R6 waiting cleared", W'(b_mail1_full), W'(0));
                repeat (3) @(posedge clk_a);
                #1;
                chk("R6 flag free", W'(a_mbf1), W'(1));
            end else begin
                repeat (4) @(posedge clk_b);
                #1;
                chk("R9 no store", W'(b_mail1_full), W'(0));
                chk("R9 flag kept", W'(a_mbf1), W'(1));
                chk("R9 inbound kept", W'(b_mbf2), W'(1));
            end
        end

        // Store ignored while busy; exact crossing latency both ways.
        a_op(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 36'h1_2345_6789);
        chk("R3 flag busy", W'(a_mbf1), W'(0));
        repeat (2) @(posedge clk_b);
        #1;
        chk("R5 not yet", W'(b_mail1_full), W'(0));
        @(posedge clk_b);
        #1;
        chk("R5 arrives", W'(b_mail1_full), W'(1));
        a_op(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 36'hF_EDCB_A987);
        repeat (3) @(posedge clk_b);
        #1;
        chk("R4 word kept", b_mail1_data, 36'h1_2345_6789);
        chk("R4 flag still busy", W'(a_mbf1), W'(0));
        b_consume();
        repeat (2) @(posedge clk_a);
        #1;
        chk("R6 not yet free", W'(a_mbf1), W'(0));
        @(posedge clk_a);
        #1;
        chk("R6 free", W'(a_mbf1), W'(1));
        a_op(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 36'hF_EDCB_A987);
        repeat (3) @(posedge clk_b);
        #1;
        chk("R3 new word", b_mail1_data, 36'hF_EDCB_A987);
        b_consume();
        repeat (3) @(posedge clk_a);
        #1;

        // Inbound mailbox.
        b_store(36'h3_0000_0033);
        chk("R7 inbound busy", W'(b_mbf2), W'(0));
        @(posedge clk_a);
        @(posedge clk_a);
        #1;
        chk("R7 not yet", W'(a_mail2_full), W'(0));
        @(posedge clk_a);
        #1;
        chk("R7 arrives", W'(a_mail2_full), W'(1));
        chk("R7 word", a_dout, 36'h3_0000_0033);
        b_store(36'h4_0000_0044);
        repeat (4) @(posedge clk_a);
        #1;
        chk("R7 busy store ignored", a_dout, 36'h3_0000_0033);
        a_op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '0);
        chk("R9 fetch disabled", W'(a_mail2_full), W'(1));
        @(negedge clk_a);
        a_cs_n = 1'b0; a_wr = 1'b0; a_en = 1'b1; a_mbx = 1'b1;
        #1;
        chk("R8 driven word", a_dout, 36'h3_0000_0033);
        @(posedge clk_a);
        #1;
        a_idle();
        chk("R8 fetched", W'(a_mail2_full), W'(0));
        repeat (2) @(posedge clk_b);
        #1;
        chk("R8 not yet free", W'(b_mbf2), W'(0));
        @(posedge clk_b);
        #1;
        chk("R8 free", W'(b_mbf2), W'(1));
        b_store(36'h4_0000_0044);
        repeat (3) @(posedge clk_a);
        #1;
        chk("R7 second word", a_dout, 36'h4_0000_0044);
        a_op(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0);
        chk("R9 deselected fetch", W'(a_mail2_full), W'(1));

        // Reset with both mailboxes occupied.
        a_op(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 36'h5_5555_5555);
        repeat (4) @(posedge clk_b);
        do_reset();

        summary();
    end
endmodule